// File: doc/BRIEF.md
# Tweak Block Counter with Domain Tagging

This block supplies two of the fields that a lightweight authenticated-encryption mode places in the tweak of each block-cipher call. The first is a block counter that moves forward by one position for every call. The second is an 8-bit domain byte that keeps the four kinds of call apart: intermediate associated data, intermediate message, final associated data and final message.

The counter is a 56-bit Galois linear-feedback shift register. Each step multiplies the state by x modulo x^56 + x^7 + x^4 + x^2 + 1. This costs a few XOR gates, where a binary incrementer of the same width would need a long carry chain. Because the polynomial has a constant term, multiplying by x can be undone, so a nonzero state never becomes zero. The sequence is long enough that no message of realistic length can run it out.

The controlling mode drives the inputs. It pulses `step_i` once per cipher call and pulses `restart_i` when the message phase begins. It holds `phase_i` and `partial_i` to describe the call being issued. The cipher and its tweakey schedule sit outside this block.

Top module: `tctr_tweak_gen`

## Requirements
- R1: After reset, `count_o` equals the seed value 1.
- R2: A step pulse without a restart updates the counter in the following cycle. Every bit moves up one position. The old bit 55 enters bit 0 and is also XORed into bits 7, 4 and 2, which is multiplication by x modulo x^56+x^7+x^4+x^2+1. Starting from the seed, k steps with k < 56 give exactly 1<<k, and step 56 gives 0x95.
- R3: In a cycle with neither a step nor a restart, `count_o` keeps its value.
- R4: A restart pulse loads the seed value 1 in the following cycle.
- R5: When a restart and a step fall in the same cycle, the restart wins and the counter becomes the seed, not the seed stepped.
- R6: `count_o` is never zero.
- R7: Phase code 0 (intermediate associated data) gives domain 8, whatever the value of `partial_i`.
- R8: Phase code 1 (intermediate message) gives domain 4, whatever the value of `partial_i`.
- R9: Phase code 2 (final associated data) gives domain 24 when `partial_i` is 0 and 26 when it is 1.
- R10: Phase code 3 (final message) gives domain 20 when `partial_i` is 0 and 21 when it is 1.
- R11: `domain_o` is combinational. It reflects `phase_i` and `partial_i` in the same cycle, and neither the counter nor the step and restart inputs affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Advance the counter once, for one cipher call |
| restart_i | input | 1 | Reload the seed at the start of the message phase |
| phase_i | input | 2 | Call kind: 0 AD mid, 1 message mid, 2 AD final, 3 message final |
| partial_i | input | 1 | The final block of this phase was padded |
| count_o | output | 56 | Counter value for the tweak |
| domain_o | output | 8 | Domain-separation byte for the tweak |

## Verification
A step and a restart can arrive in the same cycle, which happens when the last associated-data call overlaps the start of the message phase. The bench provokes this by raising both inputs in one cycle several times: at the seed, after long runs of steps, and while the phase input is changing. It judges the outcome against the rule that the seed wins, so the counter must read 1 in the next cycle and not 2. Steps taken just after each collision must then match the bench's own arithmetic model of multiplication by x.

// File: rtl/tctr_pkg.sv
package tctr_pkg;

    typedef enum logic [1:0] {
        PH_AD_MID   = 2'd0,
        PH_MSG_MID  = 2'd1,
        PH_AD_LAST  = 2'd2,
        PH_MSG_LAST = 2'd3
    } phase_e;

    localparam logic [7:0] DOM_AD_MID       = 8'd8;
    localparam logic [7:0] DOM_MSG_MID      = 8'd4;
    localparam logic [7:0] DOM_AD_LAST_FULL = 8'd24;
    localparam logic [7:0] DOM_AD_LAST_PAD  = 8'd26;
    localparam logic [7:0] DOM_MSG_LAST_FULL = 8'd20;
    localparam logic [7:0] DOM_MSG_LAST_PAD  = 8'd21;

endpackage

// File: rtl/tctr_lfsr_next.sv
module tctr_lfsr_next #(
    parameter int unsigned        WIDTH = 56,
    parameter logic [WIDTH-1:0]   TAPS  = 56'h95
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);
    localparam int unsigned TOP = WIDTH - 1;

    logic fb;
    assign fb = cur_i[TOP];

    // Multiply by x modulo the feedback polynomial: shift up, fold top bit back.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign nxt_o[i] = TAPS[i] & fb;
        end else if (TAPS[i]) begin : g_tap
            assign nxt_o[i] = cur_i[i-1] ^ fb;
        end else begin : g_plain
            assign nxt_o[i] = cur_i[i-1];
        end
    end
endmodule

// File: rtl/tctr_domain_map.sv
module tctr_domain_map
    import tctr_pkg::*;
(
    input  logic [1:0] phase_i,
    input  logic       partial_i,
    output logic [7:0] domain_o
);
    phase_e ph;
    assign ph = phase_e'(phase_i);

    always_comb begin
        unique case (ph)
            PH_AD_MID:   domain_o = DOM_AD_MID;
            PH_MSG_MID:  domain_o = DOM_MSG_MID;
            PH_AD_LAST:  domain_o = partial_i ? DOM_AD_LAST_PAD : DOM_AD_LAST_FULL;
            PH_MSG_LAST: domain_o = partial_i ? DOM_MSG_LAST_PAD : DOM_MSG_LAST_FULL;
            default:     domain_o = DOM_AD_MID;
        endcase
    end
endmodule

// File: rtl/tctr_tweak_gen.sv
module tctr_tweak_gen
    import tctr_pkg::*;
#(
    parameter int unsigned       CTR_W = 56,
    parameter logic [CTR_W-1:0]  TAPS  = 56'h95,
    parameter logic [CTR_W-1:0]  SEED  = 56'h1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             restart_i,
    input  logic [1:0]       phase_i,
    input  logic             partial_i,
    output logic [CTR_W-1:0] count_o,
    output logic [7:0]       domain_o
);
    localparam int unsigned TOP = CTR_W - 1;

    typedef struct packed {
        logic [CTR_W-1:0] ctr;
    } state_t;

    state_t           st_d, st_q;
    logic [CTR_W-1:0] ctr_stepped;

    tctr_lfsr_next #(
        .WIDTH (CTR_W),
        .TAPS  (TAPS)
    ) u_next (
        .cur_i (st_q.ctr),
        .nxt_o (ctr_stepped)
    );

    tctr_domain_map u_dom (
        .phase_i   (phase_i),
        .partial_i (partial_i),
        .domain_o  (domain_o)
    );

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.ctr = SEED;          // restart outranks a coincident step
        end else if (step_i) begin
            st_d.ctr = ctr_stepped;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.ctr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.ctr;

    // R3: idle cycles keep the counter
    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !restart_i) |=> $stable(count_o));

    // R4 and R5: restart yields the seed regardless of step
    a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (count_o == SEED));

    // R2: the old top bit re-enters at bit 0 and lower bits move up
    a_r2_rotate_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !restart_i) |=> (count_o[0] == $past(count_o[TOP])));

    a_r2_shift_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !restart_i && !count_o[TOP]) |=>
            (count_o == {$past(count_o[TOP-1:0]), 1'b0}));

    // R6: the zero state is never reached
    a_r6_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o != '0);

    // R9 and R10: final-phase domains carry bit 4, mid-phase domains do not
    a_r9_final_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_i[1] |-> domain_o[4]);

    // R7 and R8: the partial flag changes nothing in mid phases
    a_r7_mid_no_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_i[1] |-> ($countones(domain_o) == 1));

    // R10: odd domain only for a padded final message
    a_r10_pad_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        domain_o[0] |-> (partial_i && phase_i == 2'd3));
endmodule

// File: tb/sim_tctr_tweak_gen.sv
module sim_tctr_tweak_gen;
    localparam int W = 56;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step = 1'b0;
    logic         restart = 1'b0;
    logic [1:0]   phase = 2'd0;
    logic         partial = 1'b0;
    logic [W-1:0] count;
    logic [7:0]   domain;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model;

    always #4 clk = ~clk;   // 125 MHz

    tctr_tweak_gen u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .step_i    (step),
        .restart_i (restart),
        .phase_i   (phase),
        .partial_i (partial),
        .count_o   (count),
        .domain_o  (domain)
    );

    function automatic logic [W-1:0] times_x(input logic [W-1:0] v);
        logic [W-1:0] r;
        r = v << 1;
        if (v[W-1]) r = r ^ 56'h95;   // x^7 + x^4 + x^2 + 1
        return r;
    endfunction

    task automatic chk_cnt(input string req, input logic [W-1:0] exp);
        checks++;
        if (count !== exp) begin
            errors++;
            $display("FAIL %s count got %h expected %h", req, count, exp);
        end
    endtask

    task automatic chk_dom(input string req, input logic [7:0] exp);
        checks++;
        if (domain !== exp) begin
            errors++;
            $display("FAIL %s domain got %0d expected %0d", req, domain, exp);
        end
    endtask

    // one clock edge, then settle; inputs change only after the edge
    task automatic tick(input logic s, input logic r);
        step = s; restart = r;
        @(posedge clk); #1;
        step = 1'b0; restart = 1'b0;
        if (r) model = 56'h1;
        else if (s) model = times_x(model);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model = 56'h1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk_cnt("R1", 56'h1);

        // R2: powers of x from the seed, then the first fold-back
        for (int k = 1; k <= 56; k++) begin
            tick(1'b1, 1'b0);
            if (k < 56) chk_cnt("R2", 56'h1 << k);
            else        chk_cnt("R2", 56'h95);
        end

        // R3: idle cycles hold
        for (int k = 0; k < 5; k++) begin
            tick(1'b0, 1'b0);
            chk_cnt("R3", 56'h95);
        end

        // R2/R3/R6 mixed stepping pattern against the model
        for (int i = 0; i < 3000; i++) begin
            tick((i % 3) != 0, 1'b0);
            chk_cnt("R2", model);
            checks++;
            if (count == '0) begin
                errors++;
                $display("FAIL R6 count got %h expected nonzero", count);
            end
        end

        // R4: plain restart
        tick(1'b0, 1'b1);
        chk_cnt("R4", 56'h1);
        tick(1'b1, 1'b0);
        chk_cnt("R2", 56'h2);

        // R5: collision of restart and step, in several states
        for (int n = 0; n < 4; n++) begin
            for (int i = 0; i < 70 + n * 13; i++) tick(1'b1, 1'b0);
            phase = 2'(n);
            tick(1'b1, 1'b1);
            chk_cnt("R5", 56'h1);
            tick(1'b1, 1'b0);
            chk_cnt("R5", 56'h2);
        end

        // R7..R11: exhaustive phase/partial sweep, with and without step/restart
        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 2; f++) begin
                logic [7:0] e;
                phase = 2'(p); partial = f[0];
                unique case (p)
                    0: e = 8'd8;
                    1: e = 8'd4;
                    2: e = f ? 8'd26 : 8'd24;
                    default: e = f ? 8'd21 : 8'd20;
                endcase
                #1;
                case (p)
                    0: chk_dom("R7", e);
                    1: chk_dom("R8", e);
                    2: chk_dom("R9", e);
                    default: chk_dom("R10", e);
                endcase
                tick(1'b1, 1'b0);
                chk_dom("R11", e);
                chk_cnt("R2", model);
                tick(1'b0, 1'b1);
                chk_dom("R11", e);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule